// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the register state of a PCI Message Signalled Interrupt capability inside a device's configuration space. Configuration software reaches it with byte-enabled 32-bit writes, and with reads that return data combinationally. Both address it by a dword index counted from the capability base. The block keeps the message control fields, the message address, the message data and, when built with per-vector masking, a mask register and a pending register.

The delivery logic that sends interrupts reads the decoded enable bit, the allocated vector count, the address, the data and the mask from output pins. It reports vectors that are held back with pending-set strobes. It clears pending vectors it has delivered with pending-clear strobes.

Three parameters fix the build: the log2 of the capable vector count (0 to 5), 64-bit message addressing, and per-vector masking. The register layout follows from these three choices. Software writes pass through per-field write masks. A write can leave the enable bit set with a vector request larger than the capability. In that case the block cuts the request back to the capable count, and it drops any pending bits that lie above the new allocation.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the capability-ID half of dword 0 (bits 15:0) reads 0. The following fields read 0: enable (dword 0 bit 16), requested count (bits 22:20), address, data, mask and pending. The read-only fields hold their build values: capable count log2 in bits 19:17, 64-bit flag in bit 23, masking flag in bit 24.
- R2: A write to dword 0 with byte enable 2 set loads the enable bit and the requested-count field. All other dword 0 bits ignore writes.
- R3: Dword 1 is the low address. Each byte lane is written only when its byte enable is set. Bits 1:0 always read 0.
- R4: In the 64-bit build, dword 2 is the fully writable high address and dword 3 holds the data. Data is 16 bits in dword bits 15:0, written per byte enable. Dword bits 31:16 read 0.
- R5: The mask register sits one dword after the data. Only bits below the capable vector count are writable. Higher bits read 0.
- R6: The pending register sits two dwords after the data and ignores software writes. A set strobe sets a pending bit and a clear strobe clears it; when both arrive in the same cycle, set wins. Bits at or above the capable count never set.
- R7: A write that enables at least one in-capability byte may leave MSI enabled with the requested count above the capable count. The requested count then becomes the capable count in that same write. While MSI is disabled, the requested count is stored exactly as written.
- R8: A write that enables at least one in-capability byte may leave MSI enabled in a masking build. Pending bits at or above 2^(requested count) are then cleared in that same cycle.
- R9: A dword whose bytes all lie beyond the capability length ignores writes and reads 0. The capability length is 10, 14, 20 or 24 bytes, for 32-bit/64-bit without masking and 32-bit/64-bit with masking.
- R10: The output pins msi_en, vec_alloc_log2, msg_addr, msg_data, vec_mask and vec_pend always show the current register values.
- R11: In the 32-bit build without masking, dword 2 bits 15:0 hold the data and dword 3 reads 0. The mask and pending registers stay 0, and set strobes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw | input | 4 | Dword index from capability base, used for both read and write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw, combinational |
| pend_set | input | 32 | Per-vector pending set strobes |
| pend_clr | input | 32 | Per-vector pending clear strobes |
| msi_en | output | 1 | MSI enable |
| vec_alloc_log2 | output | 3 | Requested (allocated) vector count, log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| vec_pend | output | 32 | Per-vector pending bits |

## Verification
The hardest case to reach is the trimming of pending bits. It needs all three of the following together:
- pending bits above a small allocation,
- a write that ends with enable set,
- that write landing in a byte inside the capability.

The stimulus builds this up in steps. It first raises every pending vector while MSI is disabled. It then enables MSI with a small request in one write and checks that the high bits disappear. Random traffic then mixes enable toggles, over-large requests, byte-enable patterns and strobe bursts, so that clamping and trimming recur under many combinations.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int DW_W = 4;

  function automatic int cap_bytes(bit a64, bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  function automatic int data_dw(bit a64);
    return a64 ? 3 : 2;
  endfunction

  function automatic logic [31:0] low_ones(int unsigned lg);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i < (1 << lg)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int VEC_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic [7:0] wbyte,
  input  logic       touch,
  output logic       en_q,
  output logic [2:0] mme_q,
  output logic       en_nxt,
  output logic [2:0] mme_nxt
);
  localparam logic [2:0] MMC = 3'(VEC_LOG2);

  logic [2:0] mme_w;

  always_comb begin
    en_nxt = wr_ctl ? wbyte[0]   : en_q;
    mme_w  = wr_ctl ? wbyte[6:4] : mme_q;
    if (touch && en_nxt && (mme_w > MMC)) mme_nxt = MMC;
    else                                  mme_nxt = mme_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= '0;
    end else begin
      en_q  <= en_nxt;
      mme_q <= mme_nxt;
    end
  end
endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wr_data,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [15:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      data_q  <= '0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (wr_lo && be[b]) addr_lo[8*b +: 8] <= wdata[8*b +: 8] & ((b == 0) ? 8'hFC : 8'hFF);
      for (int b = 0; b < 2; b++)
        if (wr_data && be[b]) data_q[8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n) addr_hi <= '0;
        else
          for (int b = 0; b < 4; b++)
            if (wr_hi && be[b]) addr_hi[8*b +: 8] <= wdata[8*b +: 8];
      end
    end else begin : g_no_hi
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign addr_hi = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_vec.sv
module msi_cap_vec
  import msi_cap_pkg::*;
#(
  parameter int VEC_LOG2 = 3,
  parameter bit PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mask,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [31:0] pend_set,
  input  logic [31:0] pend_clr,
  input  logic        discard,
  input  logic [2:0]  alloc_log2,
  output logic [31:0] mask_q,
  output logic [31:0] pend_q
);
  localparam logic [31:0] CAP_M = low_ones(VEC_LOG2);

  generate
    if (PVM) begin : g_pvm
      logic [31:0] pend_nxt;
      always_comb begin
        pend_nxt = ((pend_q & ~pend_clr) | pend_set) & CAP_M;
        if (discard) pend_nxt = pend_nxt & low_ones(int'(alloc_log2));
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_q <= '0;
          pend_q <= '0;
        end else begin
          for (int b = 0; b < 4; b++)
            if (wr_mask && be[b]) mask_q[8*b +: 8] <= wdata[8*b +: 8] & CAP_M[8*b +: 8];
          pend_q <= pend_nxt;
        end
      end
    end else begin : g_no_pvm
      logic unused_vec;
      assign unused_vec = ^{clk, rst_n, wr_mask, be, wdata, pend_set, pend_clr, discard, alloc_log2};
      assign mask_q = '0;
      assign pend_q = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int VEC_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVM      = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [DW_W-1:0] cfg_dw,
  input  logic [3:0]      cfg_be,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [31:0]     pend_set,
  input  logic [31:0]     pend_clr,
  output logic            msi_en,
  output logic [2:0]      vec_alloc_log2,
  output logic [63:0]     msg_addr,
  output logic [15:0]     msg_data,
  output logic [31:0]     vec_mask,
  output logic [31:0]     vec_pend
);
  localparam int CAP_LEN = cap_bytes(ADDR64, PVM);
  localparam int DATA_DW = data_dw(ADDR64);
  localparam int MASK_DW = DATA_DW + 1;
  localparam int PEND_DW = DATA_DW + 2;

  logic [3:0]  in_len;
  logic        touch, wr_ctl, wr_lo, wr_hi, wr_data, wr_mask;
  logic        en_nxt;
  logic [2:0]  mme_nxt;
  logic [31:0] addr_lo, addr_hi;

  always_comb begin
    for (int i = 0; i < 4; i++)
      in_len[i] = (int'(cfg_dw) * 4 + i) < CAP_LEN;
  end

  assign touch   = cfg_wr_en && |(cfg_be & in_len);
  assign wr_ctl  = cfg_wr_en && (cfg_dw == DW_W'(0)) && cfg_be[2];
  assign wr_lo   = cfg_wr_en && (cfg_dw == DW_W'(1));
  assign wr_hi   = cfg_wr_en && ADDR64 && (cfg_dw == DW_W'(2));
  assign wr_data = cfg_wr_en && (cfg_dw == DW_W'(DATA_DW));
  assign wr_mask = cfg_wr_en && PVM && (cfg_dw == DW_W'(MASK_DW));

  msi_cap_ctrl #(.VEC_LOG2(VEC_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wbyte(cfg_wdata[23:16]),
    .touch(touch), .en_q(msi_en), .mme_q(vec_alloc_log2),
    .en_nxt(en_nxt), .mme_nxt(mme_nxt)
  );

  msi_cap_msg #(.ADDR64(ADDR64)) u_msg (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .be(cfg_be), .wdata(cfg_wdata), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .data_q(msg_data)
  );

  msi_cap_vec #(.VEC_LOG2(VEC_LOG2), .PVM(PVM)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .be(cfg_be), .wdata(cfg_wdata),
    .pend_set(pend_set), .pend_clr(pend_clr), .discard(touch && en_nxt),
    .alloc_log2(mme_nxt), .mask_q(vec_mask), .pend_q(vec_pend)
  );

  assign msg_addr = {addr_hi, addr_lo};

  always_comb begin
    cfg_rdata = '0;
    if (cfg_dw == DW_W'(0))
      cfg_rdata = {7'b0, PVM, ADDR64, vec_alloc_log2, 3'(VEC_LOG2), msi_en, 16'h0};
    else if (cfg_dw == DW_W'(1))
      cfg_rdata = addr_lo;
    else if (ADDR64 && cfg_dw == DW_W'(2))
      cfg_rdata = addr_hi;
    else if (cfg_dw == DW_W'(DATA_DW))
      cfg_rdata = {16'h0, msg_data};
    else if (PVM && cfg_dw == DW_W'(MASK_DW))
      cfg_rdata = vec_mask;
    else if (PVM && cfg_dw == DW_W'(PEND_DW))
      cfg_rdata = vec_pend;
  end
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk
  import msi_cap_pkg::*;
#(
  parameter int VEC_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVM      = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr_en,
  input logic [DW_W-1:0] cfg_dw,
  input logic [31:0]     pend_set,
  input logic            msi_en,
  input logic [2:0]      vec_alloc_log2,
  input logic [63:0]     msg_addr,
  input logic [15:0]     msg_data,
  input logic [31:0]     vec_mask,
  input logic [31:0]     vec_pend
);
  localparam logic [31:0] CAP_M = low_ones(VEC_LOG2);
  localparam int NDW = (cap_bytes(ADDR64, PVM) + 3) / 4;

  AST_EN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> (vec_alloc_log2 <= 3'(VEC_LOG2))); // R7

  AST_ADDR_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00); // R3

  AST_MASK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mask & ~CAP_M) == 32'h0); // R5

  AST_PEND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_pend & ~CAP_M) == 32'h0); // R6

  AST_PEND_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (PVM && !cfg_wr_en && ((pend_set & CAP_M) != 32'h0))
      |=> ((vec_pend & $past(pend_set & CAP_M)) == $past(pend_set & CAP_M))); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> ($stable(msg_addr) && $stable(msg_data) && $stable(vec_mask)
                    && $stable(msi_en) && $stable(vec_alloc_log2))); // R10

  AST_OUT_OF_RANGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && (int'(cfg_dw) >= NDW)) |=> ($stable(msg_addr) && $stable(msg_data)
                    && $stable(vec_mask) && $stable(msi_en))); // R9
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .PVM(PVM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw(cfg_dw), .pend_set(pend_set),
  .msi_en(msi_en), .vec_alloc_log2(vec_alloc_log2), .msg_addr(msg_addr),
  .msg_data(msg_data), .vec_mask(vec_mask), .vec_pend(vec_pend)
);

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 0;
  logic [3:0]  dw = 0, be = 0;
  logic [31:0] wd = 0, rdata, pset = 0, pclr = 0;
  logic        o_en;
  logic [2:0]  o_mme;
  logic [63:0] o_addr;
  logic [15:0] o_data;
  logic [31:0] o_mask, o_pend;

  msi_cap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_dw(dw), .cfg_be(be),
    .cfg_wdata(wd), .cfg_rdata(rdata), .pend_set(pset), .pend_clr(pclr),
    .msi_en(o_en), .vec_alloc_log2(o_mme), .msg_addr(o_addr), .msg_data(o_data),
    .vec_mask(o_mask), .vec_pend(o_pend)
  );

  logic        s_wr = 0;
  logic [3:0]  s_dw = 0, s_be = 0;
  logic [31:0] s_wd = 0, s_rdata, s_pset = 0;
  logic        s_en;
  logic [2:0]  s_mme;
  logic [63:0] s_addr;
  logic [15:0] s_data;
  logic [31:0] s_mask, s_pend;

  msi_cap_regs #(.VEC_LOG2(0), .ADDR64(1'b0), .PVM(1'b0)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(s_wr), .cfg_dw(s_dw), .cfg_be(s_be),
    .cfg_wdata(s_wd), .cfg_rdata(s_rdata), .pend_set(s_pset), .pend_clr(32'h0),
    .msi_en(s_en), .vec_alloc_log2(s_mme), .msg_addr(s_addr), .msg_data(s_data),
    .vec_mask(s_mask), .vec_pend(s_pend)
  );

  // Expected state of the default build: 8 vectors, 64-bit, masking.
  localparam logic [31:0] CAPM = 32'h0000_00FF;
  logic        m_en;
  logic [2:0]  m_mme;
  logic [31:0] m_lo, m_hi, m_mask, m_pend;
  logic [15:0] m_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] ones_below(int lg);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (i < (1 << lg)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(int d);
    case (d)
      0: return {7'b0, 1'b1, 1'b1, m_mme, 3'd3, m_en, 16'h0};
      1: return m_lo;
      2: return m_hi;
      3: return {16'h0, m_data};
      4: return m_mask;
      5: return m_pend;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int d);
    case (d)
      0: return "R2/R7";
      1: return "R3";
      2: return "R4";
      3: return "R4";
      4: return "R5";
      5: return "R6/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_mme = 0; m_lo = 0; m_hi = 0; m_data = 0; m_mask = 0; m_pend = 0;
  endtask

  task automatic model_step(logic w, int d, logic [3:0] b, logic [31:0] v,
                            logic [31:0] st, logic [31:0] cl);
    bit touch = 0;
    if (w) begin
      for (int i = 0; i < 4; i++) if (b[i] && (d * 4 + i) < 24) touch = 1;
      for (int i = 0; i < 4; i++) if (b[i]) begin
        if (d == 0 && i == 2) begin m_en = v[16]; m_mme = v[22:20]; end
        if (d == 1) m_lo[8*i +: 8] = v[8*i +: 8] & ((i == 0) ? 8'hFC : 8'hFF);
        if (d == 2) m_hi[8*i +: 8] = v[8*i +: 8];
        if (d == 3 && i < 2) m_data[8*i +: 8] = v[8*i +: 8];
        if (d == 4) m_mask[8*i +: 8] = v[8*i +: 8] & CAPM[8*i +: 8];
      end
    end
    m_pend = ((m_pend & ~cl) | st) & CAPM;
    if (touch && m_en) begin
      if (m_mme > 3'd3) m_mme = 3'd3;
      m_pend = m_pend & ones_below(int'(m_mme));
    end
  endtask

  task automatic step(logic w, int d, logic [3:0] b, logic [31:0] v,
                      logic [31:0] st, logic [31:0] cl);
    @(negedge clk);
    wr_en = w; dw = 4'(d); be = b; wd = v; pset = st; pclr = cl;
    @(posedge clk);
    #1 model_step(w, d, b, v, st, cl);
    @(negedge clk);
    wr_en = 0; pset = 0; pclr = 0;
  endtask

  task automatic check_all(string ctx);
    for (int d = 0; d < 8; d++) begin
      dw = 4'(d);
      #1 chk($sformatf("%s %s dw%0d", tag_of(d), ctx, d), 64'(rdata), 64'(exp_rd(d)));
    end
    chk({"R10 ", ctx, " outputs"},
        {o_addr[31:0], o_data, o_en, o_mme, 12'h0},
        {m_lo, m_data, m_en, m_mme, 12'h0});
    chk({"R10 ", ctx, " hi/mask/pend"}, {o_addr[63:32], o_mask ^ o_pend},
        {m_hi, m_mask ^ m_pend});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    s_dw = 0; #1 chk("R1 R11 small ctl", 64'(s_rdata), 64'h0);

    // R2: all-ones write, read-only bits hold; R7 clamp 7->3 while enabling
    step(1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0);
    check_all("R2 R7 ctl ones");
    chk("R7 clamp value", 64'(o_mme), 64'd3);
    // R7: disabled keeps oversize request
    step(1, 0, 4'h4, 32'h0070_0000, 0, 0);
    chk("R7 disabled raw", 64'(o_mme), 64'd7);
    // R2: byte enable 2 clear leaves control untouched
    step(1, 0, 4'hB, 32'h0001_0000, 0, 0);
    chk("R2 be2 off", 64'(o_en), 64'd0);
    // R3/R4 address and data by lanes
    step(1, 1, 4'h5, 32'hA5A5_A5A7, 0, 0);
    step(1, 2, 4'hF, 32'h1234_5678, 0, 0);
    step(1, 3, 4'hF, 32'hDEAD_BEEF, 0, 0);
    check_all("R3 R4 lanes");
    chk("R3 lsb", 64'(o_addr[1:0]), 64'd0);
    // R5 mask
    step(1, 4, 4'hF, 32'hFFFF_FFFF, 0, 0);
    check_all("R5 mask");
    // R6 pending: sets, write ignored, set beats clear
    step(0, 0, 4'h0, 0, 32'hFFFF_FFFF, 0);
    step(1, 5, 4'hF, 32'h0, 0, 0);
    chk("R6 pend write ignored", 64'(o_pend), 64'hFF);
    step(0, 0, 4'h0, 0, 32'h0000_0001, 32'h0000_0003);
    chk("R6 set wins", 64'(o_pend), 64'hFD);
    step(0, 0, 4'h0, 0, 32'h0000_0003, 0);
    // R8: enable with 2 vectors trims pending to bits 1:0
    step(1, 0, 4'h4, 32'h0011_0000, 0, 0);
    chk("R8 trim", 64'(o_pend), 64'h03);
    check_all("R8 trim");
    // R9: write beyond length ignored
    step(1, 6, 4'hF, 32'hFFFF_FFFF, 0, 0);
    step(1, 15, 4'hF, 32'hFFFF_FFFF, 0, 0);
    check_all("R9 oor");

    // R11: 32-bit build without masking
    @(negedge clk); s_wr = 1; s_dw = 2; s_be = 4'hF; s_wd = 32'hABCD_1234; s_pset = 32'hFFFF_FFFF;
    @(negedge clk); s_dw = 3; s_wd = 32'hFFFF_FFFF;
    @(negedge clk); s_wr = 0; s_pset = 0;
    s_dw = 2; #1 chk("R11 data dw2", 64'(s_rdata), 64'h1234);
    s_dw = 3; #1 chk("R11 dw3 zero", 64'(s_rdata), 64'h0);
    chk("R11 no mask/pend", {s_mask, s_pend}, 64'h0);
    s_dw = 0; #1 chk("R11 ctl flags", 64'(s_rdata), 64'h0);

    // random traffic
    for (int k = 0; k < 1500; k++) begin
      int d = $urandom_range(0, 7);
      logic [31:0] v = $urandom;
      logic [31:0] st = $urandom & $urandom & $urandom;
      logic [31:0] cl = $urandom & $urandom;
      logic w = ($urandom_range(0, 3) != 0);
      if (d == 0 && $urandom_range(0, 1) == 1) v[16] = 1'b1;
      step(w, d, 4'($urandom), v, st, cl);
      check_all("rand");
    end
    finish_run();
  end
endmodule